// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler with Per-Group Unit Selection

This block holds dispatched instructions until they can run, then sends them to execution units. Each instruction that arrives carries a destination tag, two source tags with their ready flags, the number of the resource group it needs, and a latency in cycles. An entry whose sources are all ready becomes eligible at once. An entry with a missing source stays parked until a write-back broadcasts the matching tag. Eligible entries are then handed to free units of their group, oldest first. Within each group the units are taken in rotating order, so that work is spread across them.

Each unit stays occupied for the instruction's latency. When that time is up, the unit reports a write-back with the destination tag. This report does three things: it frees the scheduler slot, it wakes any parked entries that wait on that tag, and it tells the retire logic that the instruction has finished. When every slot is taken, the block raises a full flag and ignores further dispatch. A dispatched instruction issues no earlier than the clock edge after the one that captured it.

Top module: `oos_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, `full_o`, every `iss_valid_o` bit and every `wb_valid_o` bit are low.
- R2: An instruction dispatched with both source flags set, whose group has a free unit, shows on `iss_valid_o` exactly one cycle after the dispatch edge and never in the same cycle.
- R3: An instruction with a source flag clear does not issue until a write-back carries that source tag. It issues one cycle after the last such write-back. This also holds when the write-back happens on the very edge that dispatches the instruction.
- R4: When several eligible entries of one group compete for fewer free units, the entry dispatched earliest issues first, whatever slot it occupies.
- R5: Issue lane n = group*UNITS + unit, so group g only uses lanes g*UNITS to g*UNITS+UNITS-1. Within a group, successive single issues rotate through the units.
- R6: An instruction issued with latency L (1 to 7) reports write-back exactly L cycles after its issue, on the same lane. The unit can take a new instruction in the cycle that write-back is reported.
- R7: Write-back reports the destination tag of the issued instruction, on the lane it issued on, and releases its slot.
- R8: `full_o` is high exactly when all DEPTH slots are occupied. A dispatch made while `full_o` is high is dropped and never issues.
- R9: No more entries issue per cycle than a group has free units. An eligible entry that finds no free unit waits, and it issues in the cycle a unit of its group reports write-back.
- R10: A latency value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_dst_i | input | TAGW | Destination tag |
| disp_srca_i | input | TAGW | First source tag |
| disp_srca_rdy_i | input | 1 | First source already available |
| disp_srcb_i | input | TAGW | Second source tag |
| disp_srcb_rdy_i | input | 1 | Second source already available |
| disp_grp_i | input | GW | Requested resource group |
| disp_lat_i | input | LATW | Execution latency in cycles |
| full_o | output | 1 | All slots occupied |
| iss_valid_o | output | GROUPS*UNITS | Issue pulse per lane |
| iss_tag_o | output | GROUPS*UNITS*TAGW | Destination tag issued per lane |
| wb_valid_o | output | GROUPS*UNITS | Write-back / retire notification per lane |
| wb_tag_o | output | GROUPS*UNITS*TAGW | Destination tag written back per lane |

## Verification
The ports can reveal a wrong slot state or a wrong ready flag, and they do so quickly. If a wake-up is lost, the consumer's issue pulse never appears one cycle after the producer's write-back. If a wake-up comes too early, the issue appears before that write-back. If the age order is wrong, the younger tag appears first on a lane when one unit frees up. If a unit count is off by one, the write-back shows up one cycle early or late relative to the issue pulse. If the occupancy count is wrong, `full_o` is out of step with the fourth dispatch, or an instruction dispatched while full still issues.

// File: rtl/oos_sched_pkg.sv
package oos_sched_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_WAIT   = 2'd1,
    SLOT_READY  = 2'd2,
    SLOT_ISSUED = 2'd3
  } slot_state_t;
endpackage

// File: rtl/sched_age_track.sv
// Relative age matrix: older_o[i][j] set means slot i was filled before slot j.
module sched_age_track #(
  parameter int DEPTH = 4,
  parameter int IW    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        alloc_en_i,
  input  logic [IW-1:0]               alloc_idx_i,
  output logic [DEPTH-1:0][DEPTH-1:0] older_o
);
  logic [DEPTH-1:0][DEPTH-1:0] older_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      older_q <= '0;
    end else if (alloc_en_i) begin
      for (int j = 0; j < DEPTH; j++) begin
        older_q[alloc_idx_i][j] <= 1'b0;
        if (IW'(j) != alloc_idx_i) older_q[j][alloc_idx_i] <= 1'b1;
      end
    end
  end

  assign older_o = older_q;

  // R4: two slots can never both be older than each other
  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    for (genvar j = i + 1; j < DEPTH; j++) begin : g_col
      p_age_order_r4: assert property (@(posedge clk) disable iff (rst)
        !(older_q[i][j] && older_q[j][i]));
    end
  end
endmodule

// File: rtl/sched_exec_unit.sv
// One execution unit: counts down the latency of the instruction it holds.
module sched_exec_unit #(
  parameter int LATW = 3,
  parameter int IW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [LATW-1:0] lat_i,
  input  logic [IW-1:0]   ent_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            free_o,
  output logic [IW-1:0]   ent_o
);
  logic            busy_q;
  logic [LATW-1:0] cnt_q;
  logic [IW-1:0]   ent_q;

  assign done_o = busy_q && (cnt_q == LATW'(1));
  assign free_o = !busy_q || done_o;
  assign busy_o = busy_q;
  assign ent_o  = ent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ent_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= (lat_i == '0) ? LATW'(1) : lat_i;
      ent_q  <= ent_i;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - LATW'(1);
    end
  end

  // R6: a unit only accepts work when it is free or finishing
  p_start_free_r6: assert property (@(posedge clk) disable iff (rst)
    start_i |-> free_o);
  // R6: a busy unit stays busy until its count runs out
  p_hold_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_o) |=> busy_q);
endmodule

// File: rtl/sched_group_pick.sv
// Per-group selector: oldest eligible entries to free units, units in rotating order.
module sched_group_pick #(
  parameter int DEPTH = 4,
  parameter int UNITS = 2,
  parameter int IW    = 2,
  parameter int UW    = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DEPTH-1:0]            ready_i,
  input  logic [DEPTH-1:0][DEPTH-1:0] older_i,
  input  logic [UNITS-1:0]            unit_free_i,
  output logic [UNITS-1:0]            grant_o,
  output logic [UNITS-1:0][IW-1:0]    grant_ent_o
);
  logic [UW-1:0]    rr_q, rr_n;
  logic [DEPTH-1:0] taken;
  int               u_sel;
  logic             found;
  logic             oldest;
  logic [IW-1:0]    pick;

  always_comb begin
    taken       = '0;
    grant_o     = '0;
    grant_ent_o = '0;
    rr_n        = rr_q;
    u_sel       = 0;
    found       = 1'b0;
    oldest      = 1'b0;
    pick        = '0;
    for (int k = 0; k < UNITS; k++) begin
      u_sel = (int'(rr_q) + k) % UNITS;
      found = 1'b0;
      pick  = '0;
      if (unit_free_i[u_sel]) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (ready_i[i] && !taken[i] && !found) begin
            oldest = 1'b1;
            for (int j = 0; j < DEPTH; j++) begin
              if (j != i && ready_i[j] && !taken[j] && older_i[j][i]) oldest = 1'b0;
            end
            if (oldest) begin
              found = 1'b1;
              pick  = IW'(i);
            end
          end
        end
        if (found) begin
          grant_o[u_sel]     = 1'b1;
          grant_ent_o[u_sel] = pick;
          taken[pick]        = 1'b1;
          rr_n               = UW'((u_sel + 1) % UNITS);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else     rr_q <= rr_n;
  end

  // R9: one entry never goes to two units in the same cycle
  for (genvar a = 0; a < UNITS; a++) begin : g_ua
    for (genvar b = a + 1; b < UNITS; b++) begin : g_ub
      p_single_grant_r9: assert property (@(posedge clk) disable iff (rst)
        !(grant_o[a] && grant_o[b] && grant_ent_o[a] == grant_ent_o[b]));
    end
  end
endmodule

// File: rtl/oos_sched.sv
module oos_sched #(
  parameter int DEPTH  = 4,
  parameter int TAGW   = 4,
  parameter int GROUPS = 2,
  parameter int UNITS  = 2,
  parameter int LATW   = 3,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int UW    = (UNITS > 1) ? $clog2(UNITS) : 1,
  localparam int NU    = GROUPS * UNITS,
  localparam int OW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_valid_i,
  input  logic [TAGW-1:0]  disp_dst_i,
  input  logic [TAGW-1:0]  disp_srca_i,
  input  logic             disp_srca_rdy_i,
  input  logic [TAGW-1:0]  disp_srcb_i,
  input  logic             disp_srcb_rdy_i,
  input  logic [GW-1:0]    disp_grp_i,
  input  logic [LATW-1:0]  disp_lat_i,
  output logic             full_o,
  output logic [NU-1:0]    iss_valid_o,
  output logic [NU*TAGW-1:0] iss_tag_o,
  output logic [NU-1:0]    wb_valid_o,
  output logic [NU*TAGW-1:0] wb_tag_o
);
  import oos_sched_pkg::*;

  // slot storage
  slot_state_t            st_q [DEPTH];
  logic [DEPTH-1:0][TAGW-1:0] dst_q, sa_q, sb_q;
  logic [DEPTH-1:0]       ra_q, rb_q;
  logic [DEPTH-1:0][GW-1:0]   grp_q;
  logic [DEPTH-1:0][LATW-1:0] lat_q;
  logic [OW-1:0]          occ_q, occ_n;
  logic                   full_q;

  // units
  logic [NU-1:0]          u_busy, u_done, u_free, u_start;
  logic [NU-1:0][IW-1:0]  u_ent, u_sent;

  // selection
  logic [DEPTH-1:0][DEPTH-1:0]          older;
  logic [GROUPS-1:0][DEPTH-1:0]         g_ready;
  logic [GROUPS-1:0][UNITS-1:0]         g_grant;
  logic [GROUPS-1:0][UNITS-1:0][IW-1:0] g_ent;

  // bookkeeping of this cycle
  logic             alloc_en, alloc_found;
  logic [IW-1:0]    alloc_idx;
  logic [DEPTH-1:0] freed, granted, wake_a, wake_b, occ_mask;
  logic             dwake_a, dwake_b;

  always_comb begin
    alloc_found = 1'b0;
    alloc_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (st_q[i] == SLOT_FREE) begin
        alloc_found = 1'b1;
        alloc_idx   = IW'(i);
      end
    end
    alloc_en = disp_valid_i && !full_q && alloc_found;
  end

  always_comb begin
    for (int g = 0; g < GROUPS; g++)
      for (int i = 0; i < DEPTH; i++)
        g_ready[g][i] = (st_q[i] == SLOT_READY) && (grp_q[i] == GW'(g));
    for (int g = 0; g < GROUPS; g++)
      for (int u = 0; u < UNITS; u++) begin
        u_start[g*UNITS+u] = g_grant[g][u];
        u_sent[g*UNITS+u]  = g_ent[g][u];
      end
  end

  always_comb begin
    freed   = '0;
    granted = '0;
    wake_a  = '0;
    wake_b  = '0;
    dwake_a = 1'b0;
    dwake_b = 1'b0;
    for (int n = 0; n < NU; n++) begin
      if (u_start[n]) granted[u_sent[n]] = 1'b1;
      if (u_done[n]) begin
        freed[u_ent[n]] = 1'b1;
        if (dst_q[u_ent[n]] == disp_srca_i) dwake_a = 1'b1;
        if (dst_q[u_ent[n]] == disp_srcb_i) dwake_b = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
          if (dst_q[u_ent[n]] == sa_q[i]) wake_a[i] = 1'b1;
          if (dst_q[u_ent[n]] == sb_q[i]) wake_b[i] = 1'b1;
        end
      end
    end
    for (int i = 0; i < DEPTH; i++) occ_mask[i] = (st_q[i] != SLOT_FREE);
    occ_n = occ_q + OW'(alloc_en) - OW'($countones(freed));
  end

  sched_age_track #(.DEPTH(DEPTH), .IW(IW)) u_age (
    .clk(clk), .rst(rst), .alloc_en_i(alloc_en), .alloc_idx_i(alloc_idx), .older_o(older)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    sched_group_pick #(.DEPTH(DEPTH), .UNITS(UNITS), .IW(IW), .UW(UW)) u_pick (
      .clk(clk), .rst(rst), .ready_i(g_ready[g]), .older_i(older),
      .unit_free_i(u_free[g*UNITS +: UNITS]),
      .grant_o(g_grant[g]), .grant_ent_o(g_ent[g])
    );
  end

  for (genvar n = 0; n < NU; n++) begin : g_unit
    sched_exec_unit #(.LATW(LATW), .IW(IW)) u_exec (
      .clk(clk), .rst(rst), .start_i(u_start[n]), .lat_i(lat_q[u_sent[n]]),
      .ent_i(u_sent[n]), .busy_o(u_busy[n]), .done_o(u_done[n]),
      .free_o(u_free[n]), .ent_o(u_ent[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_FREE;
      dst_q <= '0; sa_q <= '0; sb_q <= '0;
      ra_q <= '0; rb_q <= '0; grp_q <= '0; lat_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_en && alloc_idx == IW'(i)) begin
          dst_q[i] <= disp_dst_i;
          sa_q[i]  <= disp_srca_i;
          sb_q[i]  <= disp_srcb_i;
          ra_q[i]  <= disp_srca_rdy_i | dwake_a;
          rb_q[i]  <= disp_srcb_rdy_i | dwake_b;
          grp_q[i] <= disp_grp_i;
          lat_q[i] <= disp_lat_i;
          st_q[i]  <= ((disp_srca_rdy_i | dwake_a) && (disp_srcb_rdy_i | dwake_b))
                      ? SLOT_READY : SLOT_WAIT;
        end else begin
          case (st_q[i])
            SLOT_WAIT: begin
              ra_q[i] <= ra_q[i] | wake_a[i];
              rb_q[i] <= rb_q[i] | wake_b[i];
              if ((ra_q[i] | wake_a[i]) && (rb_q[i] | wake_b[i])) st_q[i] <= SLOT_READY;
            end
            SLOT_READY:  if (granted[i]) st_q[i] <= SLOT_ISSUED;
            SLOT_ISSUED: if (freed[i])   st_q[i] <= SLOT_FREE;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q       <= '0;
      full_q      <= 1'b0;
      iss_valid_o <= '0;
      iss_tag_o   <= '0;
      wb_valid_o  <= '0;
      wb_tag_o    <= '0;
    end else begin
      occ_q  <= occ_n;
      full_q <= (occ_n == OW'(DEPTH));
      for (int n = 0; n < NU; n++) begin
        iss_valid_o[n]            <= u_start[n];
        iss_tag_o[n*TAGW +: TAGW] <= dst_q[u_sent[n]];
        wb_valid_o[n]             <= u_done[n];
        wb_tag_o[n*TAGW +: TAGW]  <= dst_q[u_ent[n]];
      end
    end
  end

  assign full_o = full_q;

  // R8: occupancy counter and slot states agree on fullness
  p_full_match_r8: assert property (@(posedge clk) disable iff (rst)
    full_q == ($countones(occ_mask) == DEPTH));

  for (genvar n = 0; n < NU; n++) begin : g_chk
    // R3: only slots whose operands are all present reach a unit
    p_issue_ready_r3: assert property (@(posedge clk) disable iff (rst)
      u_start[n] |-> (st_q[u_sent[n]] == SLOT_READY));
    // R7: a finishing unit always refers to an issued slot
    p_wb_issued_r7: assert property (@(posedge clk) disable iff (rst)
      u_done[n] |-> (st_q[u_ent[n]] == SLOT_ISSUED));
  end
endmodule

// File: tb/oos_sched_tb.sv
`timescale 1ns/1ps
module oos_sched_tb;
  localparam int TAGW = 4;
  localparam int NU   = 4;
  localparam int UNITS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_valid = 1'b0;
  logic [TAGW-1:0] disp_dst = '0, disp_srca = '0, disp_srcb = '0;
  logic disp_srca_rdy = 1'b0, disp_srcb_rdy = 1'b0;
  logic [0:0] disp_grp = '0;
  logic [2:0] disp_lat = '0;
  logic full;
  logic [NU-1:0] iss_valid, wb_valid;
  logic [NU*TAGW-1:0] iss_tag, wb_tag;

  always #2 clk = ~clk;

  oos_sched u_dut (
    .clk(clk), .rst(rst), .disp_valid_i(disp_valid), .disp_dst_i(disp_dst),
    .disp_srca_i(disp_srca), .disp_srca_rdy_i(disp_srca_rdy),
    .disp_srcb_i(disp_srcb), .disp_srcb_rdy_i(disp_srcb_rdy),
    .disp_grp_i(disp_grp), .disp_lat_i(disp_lat), .full_o(full),
    .iss_valid_o(iss_valid), .iss_tag_o(iss_tag),
    .wb_valid_o(wb_valid), .wb_tag_o(wb_tag)
  );

  int total = 0, bad = 0, cyc = 0;
  int iss_cyc [16], iss_unit [16], iss_cnt [16];
  int wb_cyc [16], wb_unit [16], disp_cyc [16];
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int t = 0; t < 16; t++) begin
      iss_cyc[t] = -1; iss_unit[t] = -1; iss_cnt[t] = 0;
      wb_cyc[t] = -1; wb_unit[t] = -1; disp_cyc[t] = -1;
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    for (int n = 0; n < NU; n++) begin
      if (iss_valid[n]) begin
        iss_cyc[iss_tag[n*TAGW +: TAGW]]  = cyc;
        iss_unit[iss_tag[n*TAGW +: TAGW]] = n;
        iss_cnt[iss_tag[n*TAGW +: TAGW]]++;
      end
      if (wb_valid[n]) begin
        wb_cyc[wb_tag[n*TAGW +: TAGW]]  = cyc;
        wb_unit[wb_tag[n*TAGW +: TAGW]] = n;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic dispatch(input int tag, input int sa, input bit ra,
                          input int sb, input bit rb, input int grp, input int lat);
    disp_valid = 1'b1; disp_dst = TAGW'(tag);
    disp_srca = TAGW'(sa); disp_srca_rdy = ra;
    disp_srcb = TAGW'(sb); disp_srcb_rdy = rb;
    disp_grp = 1'(grp); disp_lat = 3'(lat);
    step();
    disp_valid = 1'b0;
    disp_cyc[tag] = cyc;
  endtask

  initial begin
    int d;
    clear_log();
    idle(3);
    // R1: outputs quiet in reset
    chk(full == 1'b0 && iss_valid == '0 && wb_valid == '0, "R1 in reset",
        int'({full, iss_valid, wb_valid}), 0);
    rst = 1'b0;
    step();
    chk(full == 1'b0 && iss_valid == '0 && wb_valid == '0, "R1 after reset",
        int'({full, iss_valid, wb_valid}), 0);

    // Sweep of group and latency: R2, R5 lane range, R6, R7, R10
    for (int g = 0; g < 2; g++) begin
      for (int lat = 0; lat < 8; lat++) begin
        int tg, el;
        tg = g * 8 + lat;
        el = (lat == 0) ? 1 : lat;
        dispatch(tg, 0, 1'b1, 0, 1'b1, g, lat);
        idle(lat + 3);
        chk(iss_cyc[tg] == disp_cyc[tg] + 1, "R2 issue one cycle after dispatch",
            iss_cyc[tg], disp_cyc[tg] + 1);
        chk(iss_unit[tg] / UNITS == g, "R5 lane inside requested group",
            iss_unit[tg] / UNITS, g);
        if (lat == 0)
          chk(wb_cyc[tg] == iss_cyc[tg] + 1, "R10 latency zero acts as one",
              wb_cyc[tg], iss_cyc[tg] + 1);
        else
          chk(wb_cyc[tg] == iss_cyc[tg] + el, "R6 write-back after latency",
              wb_cyc[tg], iss_cyc[tg] + el);
        chk(wb_unit[tg] == iss_unit[tg], "R7 write-back tag on issuing lane",
            wb_unit[tg], iss_unit[tg]);
      end
    end
    idle(5);

    // R5: rotation among units of a group
    for (int g = 0; g < 2; g++) begin
      clear_log();
      for (int t = 0; t < 4; t++) begin
        dispatch(t, 0, 1'b1, 0, 1'b1, g, 1);
        idle(3);
      end
      for (int t = 1; t < 4; t++)
        chk(iss_unit[t] != iss_unit[t-1] && iss_unit[t] / UNITS == g,
            "R5 units alternate", iss_unit[t], iss_unit[t-1] ^ 1);
    end
    idle(5);

    // R4, R8, R9: both units of group 1 busy, two waiting entries, buffer full
    clear_log();
    dispatch(1, 0, 1'b1, 0, 1'b1, 1, 5);
    dispatch(2, 0, 1'b1, 0, 1'b1, 1, 5);
    dispatch(3, 0, 1'b1, 0, 1'b1, 1, 1);
    dispatch(4, 0, 1'b1, 0, 1'b1, 1, 1);
    chk(full == 1'b1, "R8 full after fourth entry", int'(full), 1);
    dispatch(5, 0, 1'b1, 0, 1'b1, 0, 1);
    idle(15);
    chk(full == 1'b0, "R8 full clears after drain", int'(full), 0);
    chk(wb_cyc[1] == disp_cyc[1] + 6, "R6 first blocker latency", wb_cyc[1], disp_cyc[1] + 6);
    chk(iss_cyc[3] == wb_cyc[1], "R9 waiting entry takes freed unit", iss_cyc[3], wb_cyc[1]);
    chk(iss_cyc[4] == wb_cyc[2], "R9 second waiting entry on next free", iss_cyc[4], wb_cyc[2]);
    chk(iss_cyc[3] < iss_cyc[4], "R4 older issues first", iss_cyc[3], iss_cyc[4]);
    chk(iss_cnt[5] == 0, "R8 dispatch while full dropped", iss_cnt[5], 0);
    idle(5);

    // R4 with slot order opposite to age order
    clear_log();
    dispatch(1, 0, 1'b1, 0, 1'b1, 1, 2);   // slot 0, leaves early
    dispatch(2, 0, 1'b1, 0, 1'b1, 0, 7);   // slot 1
    dispatch(3, 0, 1'b1, 0, 1'b1, 0, 7);   // slot 2
    dispatch(4, 0, 1'b1, 0, 1'b1, 0, 1);   // slot 3, older
    dispatch(5, 0, 1'b1, 0, 1'b1, 0, 1);   // slot 0 reused, younger
    idle(16);
    chk(wb_cyc[1] == disp_cyc[4], "R7 early slot released", wb_cyc[1], disp_cyc[4]);
    chk(iss_cyc[4] == wb_cyc[2], "R9 older takes first freed unit", iss_cyc[4], wb_cyc[2]);
    chk(iss_cyc[4] < iss_cyc[5], "R4 age beats slot index", iss_cyc[4], iss_cyc[5]);
    idle(5);

    // R3: wake-up by write-back tag
    clear_log();
    dispatch(6, 0, 1'b1, 0, 1'b1, 0, 4);
    dispatch(7, 6, 1'b0, 0, 1'b1, 1, 1);
    idle(10);
    chk(wb_cyc[6] == disp_cyc[6] + 5, "R6 producer latency", wb_cyc[6], disp_cyc[6] + 5);
    chk(iss_cyc[7] == wb_cyc[6] + 1, "R3 consumer after producer", iss_cyc[7], wb_cyc[6] + 1);

    clear_log();
    dispatch(8, 0, 1'b1, 0, 1'b1, 0, 2);
    dispatch(9, 0, 1'b1, 0, 1'b1, 1, 6);
    dispatch(10, 8, 1'b0, 9, 1'b0, 0, 1);
    idle(14);
    chk(iss_cyc[10] == wb_cyc[9] + 1, "R3 waits for last source", iss_cyc[10], wb_cyc[9] + 1);
    chk(iss_cyc[10] > wb_cyc[8] + 1, "R3 one source is not enough", iss_cyc[10], wb_cyc[8] + 2);

    clear_log();
    dispatch(11, 0, 1'b1, 0, 1'b1, 1, 2);
    idle(2);
    dispatch(12, 11, 1'b0, 0, 1'b1, 0, 1);
    idle(5);
    d = disp_cyc[12];
    chk(wb_cyc[11] == d, "R3 write-back on dispatch edge", wb_cyc[11], d);
    chk(iss_cyc[12] == d + 1, "R3 same-edge wake captured", iss_cyc[12], d + 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end
endmodule